// File: doc/BRIEF.md
# Interleaved Three-Level Multiphase PWM Generator

This block drives the twelve power switches of three parallel three-level DC-DC converter legs. Each leg has four series switches. The outer switch of each half is set by comparing a duty command with a triangular carrier. The inner switch of that half is the complement of the outer one. The block derives six triangular carriers from one shared time base, two per leg. The carriers are staggered in sixths of the switching period so that the output-current ripple of the three legs partly cancels.

A controller supplies the duty command, the carrier peak (which sets the period) and a dead time in clock cycles. The block latches a new command and a new peak once per period, at one fixed carrier peak. It then inserts dead time into every complementary pair. While the block is in reset or disabled, every gate is off. With a 50 MHz clock, a peak of 500 gives the nominal 50 kHz switching frequency.

Top module: `ilpwm_gen`

## Requirements
- R1: Gate bit 4*L+0 is the top switch of leg L (L = 0, 1, 2). Bit 4*L+1 is its complement, bit 4*L+2 is the complement of the bottom switch, and bit 4*L+3 is the bottom switch. The two switches of a complementary pair are never on in the same cycle.
- R2: The switching period is 2*P clock cycles, where P is the effective peak. P equals the peak setting, raised to 3 when the setting is below 3.
- R3: For a latched command c with 0 < c < P, each top and bottom switch reference is high for 2*c cycles of every period. With dead time D, the switch itself is on for 2*c-D cycles and its complement for 2*P-2*c-D cycles.
- R4: A command c >= P holds every top and bottom switch on and its complement off. A command of zero holds every top and bottom switch off and its complement on.
- R5: The switch turn-ons rotate in steps of one sixth of the period (P/3 cycles) in this order: leg 0 top, leg 2 bottom, leg 1 top, leg 0 bottom, leg 2 top, leg 1 bottom.
- R6: Within a leg, the bottom switch turns on exactly P cycles (half a period) after the top switch.
- R7: After either switch of a pair turns off, both switches stay off for exactly D cycles before the partner turns on.
- R8: The command and the peak are latched only when the leg 0 top carrier reaches its peak. Each leg 0 top pulse therefore reflects a single command value, even when the command changes during that pulse.
- R9: All twelve gates are off while reset is asserted. They are also off from the first clock edge at which the enable input is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces all gates off and reloads the settings |
| duty_cmd | input | CW | Duty command compared with the carriers |
| peak_set | input | CW | Carrier peak; the period is twice this value |
| dead_set | input | DTW | Dead time in clock cycles |
| gate | output | 12 | Gate drives, four per leg as laid out in R1 |

## Verification
A comparison result reaches a gate one clock after the shared phase counter advances. The D cycles of dead time are added on top of that, so the bench waits several whole periods after any change of settings before it measures. It then checks counts over a full period and distances between edges, and neither depends on the absolute alignment. A new command takes effect only at the next leg 0 top carrier peak. The latching check therefore records the very pulse during which the command changed and accepts only the old width or the new one. Disable acts on the next edge, so the all-off window begins at the first falling clock edge after en is driven low.

// File: rtl/ilpwm_pkg.sv
package ilpwm_pkg;
  localparam int LEGS       = 3;
  localparam int CARRIERS   = 2 * LEGS;
  localparam int PEAK_FLOOR = 3;

  // Carrier k = 2*leg + (0 upper, 1 lower); result is valley position in sixths.
  function automatic int unsigned slot_of(input int unsigned k);
    if (k % 2 == 0) return k;
    return (k - 1 + LEGS) % CARRIERS;
  endfunction

  function automatic int unsigned clamp_peak(input int unsigned p);
    return (p < PEAK_FLOOR) ? PEAK_FLOOR : p;
  endfunction

  // Position of a carrier inside its own period, valley at zero.
  function automatic int unsigned phase_q(input int unsigned pos,
                                          input int unsigned peak,
                                          input int unsigned slot);
    int unsigned per;
    int unsigned off;
    int unsigned q;
    per = 2 * peak;
    off = (slot * per) / CARRIERS;
    q   = pos + per - off;
    if (q >= per) q = q - per;
    if (q >= per) q = q - per;
    return q;
  endfunction

  // Reference is high for 2*cmd positions centred on the valley.
  function automatic logic ref_on(input int unsigned q,
                                  input int unsigned cmd,
                                  input int unsigned peak);
    if (cmd >= peak) return 1'b1;
    if (cmd == 0) return 1'b0;
    return (q <= cmd) || (q > 2 * peak - cmd);
  endfunction
endpackage

// File: rtl/ilpwm_timebase.sv
module ilpwm_timebase
  import ilpwm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cmd_in,
  input  logic [CW-1:0] peak_in,
  output logic [CW:0]   pos,
  output logic [CW-1:0] cmd_q,
  output logic [CW-1:0] peak_q
);
  localparam int PW = CW + 1;

  logic [PW-1:0] per_w;
  logic          wrap_w;
  logic          upd_w;
  logic [CW-1:0] peak_eff_w;

  assign peak_eff_w = CW'(clamp_peak(32'(peak_in)));
  assign per_w      = {peak_q, 1'b0};
  assign wrap_w     = (pos >= per_w - PW'(1));
  assign upd_w      = (pos == PW'(peak_q) - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      cmd_q  <= '0;
      peak_q <= CW'(PEAK_FLOOR);
    end else if (!en) begin
      pos    <= '0;
      cmd_q  <= cmd_in;
      peak_q <= peak_eff_w;
    end else begin
      pos <= wrap_w ? '0 : pos + PW'(1);
      if (upd_w) begin
        cmd_q  <= cmd_in;
        peak_q <= peak_eff_w;
      end
    end
  end

  // Settings move only at the leg 0 top carrier peak while running
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(upd_w)) |-> ($stable(cmd_q) && $stable(peak_q)));

  // The period closes back to the valley
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap_w) |=> (pos == '0));
endmodule

// File: rtl/ilpwm_carrier.sv
module ilpwm_carrier
  import ilpwm_pkg::*;
#(
  parameter int          CW   = 12,
  parameter int unsigned SLOT = 0
) (
  input  logic [CW:0]   pos,
  input  logic [CW-1:0] cmd,
  input  logic [CW-1:0] peak,
  output logic          on
);
  always_comb begin
    on = ref_on(phase_q(32'(pos), 32'(peak), SLOT), 32'(cmd), 32'(peak));
  end
endmodule

// File: rtl/ilpwm_deadband.sv
module ilpwm_deadband #(
  parameter int DTW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           ref_in,
  input  logic [DTW-1:0] dead,
  output logic           hi,
  output logic           lo
);
  logic           ref_q;
  logic           live_q;
  logic [DTW-1:0] cnt_q;
  logic           quiet_w;

  assign quiet_w = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      live_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!run) begin
      ref_q  <= 1'b0;
      live_q <= 1'b0;
      cnt_q  <= dead;
    end else begin
      live_q <= 1'b1;
      if (ref_in != ref_q) begin
        ref_q <= ref_in;
        cnt_q <= dead;
      end else if (!quiet_w) begin
        cnt_q <= cnt_q - DTW'(1);
      end
    end
  end

  assign hi = live_q & quiet_w & ref_q;
  assign lo = live_q & quiet_w & ~ref_q;

  // A direct hand-over between partners is only legal with zero dead time
  assert_gap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hi) && lo) |-> (dead == '0));
  assert_gap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lo) && hi) |-> (dead == '0));

  // Disable forces the pair off on the next edge
  assert_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!hi && !lo));
endmodule

// File: rtl/ilpwm_gen.sv
module ilpwm_gen
  import ilpwm_pkg::*;
#(
  parameter int CW  = 12,
  parameter int DTW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CW-1:0]     duty_cmd,
  input  logic [CW-1:0]     peak_set,
  input  logic [DTW-1:0]    dead_set,
  output logic [4*LEGS-1:0] gate
);
  logic [CW:0]         pos_w;
  logic [CW-1:0]       cmd_w;
  logic [CW-1:0]       peak_w;
  logic [CARRIERS-1:0] ref_w;
  logic [CARRIERS-1:0] hi_w;
  logic [CARRIERS-1:0] lo_w;

  ilpwm_timebase #(.CW(CW)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .cmd_in (duty_cmd),
    .peak_in(peak_set),
    .pos    (pos_w),
    .cmd_q  (cmd_w),
    .peak_q (peak_w)
  );

  for (genvar k = 0; k < CARRIERS; k++) begin : g_car
    localparam int LEG = k / 2;

    ilpwm_carrier #(.CW(CW), .SLOT(slot_of(k))) u_car (
      .pos (pos_w),
      .cmd (cmd_w),
      .peak(peak_w),
      .on  (ref_w[k])
    );

    ilpwm_deadband #(.DTW(DTW)) u_db (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en),
      .ref_in(ref_w[k]),
      .dead  (dead_set),
      .hi    (hi_w[k]),
      .lo    (lo_w[k])
    );

    if (k % 2 == 0) begin : g_top
      assign gate[4*LEG+0] = hi_w[k];
      assign gate[4*LEG+1] = lo_w[k];
    end else begin : g_bot
      assign gate[4*LEG+3] = hi_w[k];
      assign gate[4*LEG+2] = lo_w[k];
    end
  end

  for (genvar l = 0; l < LEGS; l++) begin : g_chk
    assert_pair_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[4*l+0] && gate[4*l+1]));
    assert_pair_bot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[4*l+2] && gate[4*l+3]));
  end
endmodule

// File: tb/tb_ilpwm_gen.sv
module tb_ilpwm_gen;
  localparam int CW  = 12;
  localparam int DTW = 6;

  localparam int K_COUNT  = 0;
  localparam int K_PHASE  = 1;
  localparam int K_GAP    = 2;
  localparam int K_WIDTHS = 3;
  localparam int K_OFF    = 4;
  localparam int K_PAIR   = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [CW-1:0]  duty_cmd = '0;
  logic [CW-1:0]  peak_set = CW'(30);
  logic [DTW-1:0] dead_set = DTW'(3);
  logic [11:0]    gate;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    int    kind;
    int    idx;
    int    ref_idx;
    int    win;
    int    expa;
    int    expb;
    string tag;
  } item_t;

  item_t sbq[$];

  always #10 clk = ~clk;

  ilpwm_gen #(.CW(CW), .DTW(DTW)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .duty_cmd(duty_cmd),
    .peak_set(peak_set),
    .dead_set(dead_set),
    .gate    (gate)
  );

  task automatic push(input int kind, input int idx, input int ref_idx, input int win,
                      input int expa, input int expb, input string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.ref_idx = ref_idx; it.win = win;
    it.expa = expa; it.expb = expb; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report(input string tag, input int act, input int expv, input bit ok);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic seek_edge(input int idx, input bit rising);
    logic prev;
    prev = gate[idx];
    forever begin
      @(negedge clk);
      if (rising ? (!prev && gate[idx]) : (prev && !gate[idx])) break;
      prev = gate[idx];
    end
  endtask

  // Monitor: pops each expected item and measures it at the ports
  initial begin
    item_t it;
    int    act;
    int    bad;
    forever begin
      while (sbq.size() == 0) @(negedge clk);
      it = sbq[0];
      case (it.kind)
        K_COUNT: begin
          act = 0;
          for (int t = 0; t < it.win; t++) begin
            @(negedge clk);
            if (gate[it.idx]) act++;
          end
          report(it.tag, act, it.expa, act == it.expa);
        end
        K_PHASE: begin
          seek_edge(it.ref_idx, 1'b1);
          act = -1;
          begin
            logic prev;
            prev = gate[it.idx];
            for (int t = 1; t <= it.win; t++) begin
              @(negedge clk);
              if (!prev && gate[it.idx]) begin act = t; break; end
              prev = gate[it.idx];
            end
          end
          report(it.tag, act, it.expa, act == it.expa);
        end
        K_GAP: begin
          seek_edge(it.idx, 1'b0);
          act = 0;
          while (!gate[it.ref_idx] && !gate[it.idx] && act < 200) begin
            act++;
            @(negedge clk);
          end
          report(it.tag, act, it.expa, act == it.expa);
        end
        K_WIDTHS: begin
          bad = -1;
          for (int p = 0; p < it.win; p++) begin
            seek_edge(it.idx, 1'b1);
            act = 0;
            while (gate[it.idx]) begin
              act++;
              @(negedge clk);
            end
            if (act != it.expa && act != it.expb && bad < 0) bad = act;
          end
          report(it.tag, bad, it.expa, bad < 0);
        end
        K_OFF: begin
          bad = 0;
          for (int t = 0; t < it.win; t++) begin
            @(negedge clk);
            if (gate != '0) bad = int'(gate);
          end
          report(it.tag, bad, 0, bad == 0);
        end
        default: begin
          bad = 0;
          for (int t = 0; t < it.win; t++) begin
            @(negedge clk);
            for (int l = 0; l < 3; l++) begin
              if ((gate[4*l] && gate[4*l+1]) || (gate[4*l+2] && gate[4*l+3])) bad++;
            end
          end
          report(it.tag, bad, 0, bad == 0);
        end
      endcase
      void'(sbq.pop_front());
    end
  end

  // Driver
  initial begin
    // R9: reset holds every gate off
    push(K_OFF, 0, 0, 5, 0, 0, "R9 reset all off");
    drain();
    rst_n = 1'b1;

    // P=30 (period 60), D=3, c=12
    duty_cmd = CW'(12); peak_set = CW'(30); dead_set = DTW'(3);
    en = 1'b1;
    settle(200);
    push(K_COUNT, 0, 0, 60, 21, 0, "R3 leg0 top on-time");
    push(K_COUNT, 1, 0, 60, 33, 0, "R3 leg0 top complement");
    push(K_COUNT, 3, 0, 60, 21, 0, "R3 leg0 bottom on-time");
    push(K_COUNT, 2, 0, 60, 33, 0, "R3 leg0 bottom complement");
    push(K_COUNT, 8, 0, 60, 21, 0, "R3 leg2 top on-time");
    push(K_PHASE, 3, 0, 62, 30, 0, "R6 leg0 bottom half period");
    push(K_PHASE, 11, 0, 62, 10, 0, "R5 leg2 bottom second slot");
    push(K_PHASE, 4, 0, 62, 20, 0, "R5 leg1 top third slot");
    push(K_PHASE, 8, 0, 62, 40, 0, "R5 leg2 top fifth slot");
    push(K_PHASE, 7, 0, 62, 50, 0, "R5 leg1 bottom sixth slot");
    push(K_GAP, 0, 1, 0, 3, 0, "R7 top pair dead time");
    push(K_GAP, 7, 6, 0, 3, 0, "R7 leg1 bottom pair dead time");
    push(K_PAIR, 0, 0, 120, 0, 0, "R1 pairs exclusive");
    drain();

    // R8: change the command in the middle of a leg 0 top pulse
    push(K_WIDTHS, 0, 0, 4, 21, 9, "R8 single command per pulse");
    seek_edge(0, 1'b1);
    settle(5);
    duty_cmd = CW'(6);
    drain();

    // R4: saturated and zero commands
    duty_cmd = CW'(30);
    settle(150);
    push(K_COUNT, 0, 0, 60, 60, 0, "R4 command at peak top on");
    push(K_COUNT, 1, 0, 60, 0, 0, "R4 command at peak complement off");
    drain();
    duty_cmd = CW'(40);
    settle(150);
    push(K_COUNT, 4, 0, 60, 60, 0, "R4 command above peak top on");
    drain();
    duty_cmd = CW'(0);
    settle(150);
    push(K_COUNT, 0, 0, 60, 0, 0, "R4 zero command top off");
    push(K_COUNT, 1, 0, 60, 60, 0, "R4 zero command complement on");
    push(K_COUNT, 3, 0, 60, 0, 0, "R4 zero command bottom off");
    push(K_COUNT, 2, 0, 60, 60, 0, "R4 zero command bottom complement on");
    drain();

    // R2: peak below the floor is raised to 3 (period 6)
    en = 1'b0;
    settle(2);
    peak_set = CW'(1); duty_cmd = CW'(1); dead_set = DTW'(0);
    settle(2);
    en = 1'b1;
    settle(100);
    push(K_COUNT, 0, 0, 6, 2, 0, "R2 clamped peak top on-time");
    push(K_COUNT, 1, 0, 6, 4, 0, "R2 clamped peak complement");
    push(K_PHASE, 0, 0, 20, 6, 0, "R2 clamped period");
    drain();

    // R2/R3/R6 with P=45, D=0, c=15
    en = 1'b0;
    settle(2);
    peak_set = CW'(45); duty_cmd = CW'(15);
    settle(2);
    en = 1'b1;
    settle(300);
    push(K_COUNT, 0, 0, 90, 30, 0, "R3 wide period on-time");
    push(K_PHASE, 0, 0, 100, 90, 0, "R2 wide period");
    push(K_PHASE, 3, 0, 92, 45, 0, "R6 wide half period");
    push(K_GAP, 0, 1, 0, 0, 0, "R7 zero dead time hand-over");
    drain();

    // R9: disable turns every gate off from the next edge
    en = 1'b0;
    push(K_OFF, 0, 0, 20, 0, 0, "R9 disable all off");
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule